// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps calendar time (seconds, minutes, hours, day of week, date, month and two-digit year) from a 32.768 kHz enable strobe. A prescaler turns that strobe into a once-per-second event. A small sequencer then walks through the fields one clock per field, passing the carry from each field to the next. Every field can be held either as packed BCD or as plain binary, and the hour field can run in 24-hour or 12-hour form. In 12-hour form, bit 7 of the hour byte flags PM.

Software works through a byte-wide register port. A write strobe loads a byte, and the read data follows the address combinationally. Three alarm bytes sit next to the time fields. A control byte holds the format bits and a freeze bit: while the freeze bit is set, no update runs, so a new time can be loaded safely.

A busy flag warns that an update is coming. It rises a programmable number of reference ticks before any field changes and stays high until the update window closes. When the flag falls, the block emits a one-cycle done pulse. In that same cycle it emits an alarm pulse if the updated seconds, minutes and hours equal the alarm bytes.

The sequencer states are:
- IDLE
- WARN (busy, waiting for the second boundary)
- SEC, MIN, HOUR, WDAY, MDAY, MON and YEAR (one field each)
- MATCH (alarm compare)
- HOLD (rest of the busy window)
- END (done pulse)

The transitions are:
- IDLE→WARN on the lead event, when not frozen.
- WARN→IDLE if frozen.
- WARN→SEC on the second event.
- SEC through YEAR and MATCH advance one state per clock.
- MATCH→HOLD.
- HOLD→END after HOLD_TICKS reference ticks.
- END→IDLE.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the bytes read as follows: addresses 0–5 read 0x00, address 6 reads 0x01, addresses 7 and 8 read 0x01, address 9 reads 0x00, address 10 reads 0x20, address 11 reads 0x02, address 12 reads 0x00 and address 13 reads 0x80. The outputs `uip`, `upd_done` and `alarm_hit` are 0.
- R2: The address map is: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 day of week, 7 date, 8 month, 9 year, 10 status, 11 control. Each of bytes 0–9 reads back the value last written to it.
- R3: Seconds advance once per TICKS_PER_SEC reference ticks. Seconds wrap 59→0 and carry into minutes, minutes wrap 59→0 and carry into hours, and hours wrap 23→0 and carry into both day of week and date.
- R4: Control bit 2 selects the data format: 0 means packed BCD (tens in bits 7:4, units in bits 3:0) and 1 means plain binary. All counting obeys the selected format.
- R5: When control bit 1 is 0, hours run in 12-hour form with 1–12 in bits 6:0 and PM in bit 7. In that form, 11 AM rolls to 12 PM, 12 PM rolls to 1 PM, and 11 PM rolls to 12 AM on the next day. When control bit 1 is 1, hours run 0–23.
- R6: The date wraps after the last day of the month: 30 days for months 4, 6, 9 and 11; 29 for month 2 when the year is divisible by 4, otherwise 28; 31 for all other months. The month wraps 12→1 and carries into the year, and the year wraps 99→0.
- R7: Day of week counts 1 to 7 and wraps 7→1.
- R8: While control bit 7 is 1, no update runs. The time fields then change only through writes, and the prescaler restarts from zero.
- R9: `uip`, which is also bit 7 of address 10, rises LEAD_TICKS reference ticks before the seconds field changes, so the fields still hold their old values when it rises.
- R10: `upd_done` is a one-cycle pulse in the cycle in which `uip` falls at the end of an update.
- R11: `alarm_hit` pulses together with `upd_done` when the updated seconds, minutes and hours equal bytes 1, 3 and 5. The comparison is made on decoded 24-hour values.
- R12: Bit 7 of address 10 is read-only. Address 12 always reads 0x00 and address 13 always reads 0x80, and writes to either of them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| uip | output | 1 | Update-in-progress flag |
| upd_done | output | 1 | One-cycle pulse at the end of an update |
| alarm_hit | output | 1 | One-cycle alarm-match pulse |

## Verification
The bench targets the rollovers where a wrong carry shows up at once:
- Seconds, minutes and hours all wrapping together at New Year. A broken carry chain leaves a stale minute or date.
- 29 February in a leap year and 28 February in a common year. A wrong month-length table either skips the leap day or invents one.
- The three 12-hour transitions around noon and midnight. A design that mishandles the 12 code shows 0 or 13 with the wrong PM bit.

It also loads the same times in both BCD and binary, so a decimal-adjust slip produces hex digits above 9. It checks that the seconds are still old when the busy flag rises, that freezing stops all updates, and that the alarm fires only on the exact second that matches.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WARN, ST_SEC, ST_MIN, ST_HOUR, ST_WDAY,
        ST_MDAY, ST_MON, ST_YEAR, ST_MATCH, ST_HOLD, ST_END
    } seq_state_t;

    localparam int NUM_FIELDS = 10;

    localparam logic [3:0] A_SEC   = 4'd0;
    localparam logic [3:0] A_ASEC  = 4'd1;
    localparam logic [3:0] A_MIN   = 4'd2;
    localparam logic [3:0] A_AMIN  = 4'd3;
    localparam logic [3:0] A_HOUR  = 4'd4;
    localparam logic [3:0] A_AHOUR = 4'd5;
    localparam logic [3:0] A_WDAY  = 4'd6;
    localparam logic [3:0] A_MDAY  = 4'd7;
    localparam logic [3:0] A_MON   = 4'd8;
    localparam logic [3:0] A_YEAR  = 4'd9;
    localparam logic [3:0] A_STAT  = 4'd10;
    localparam logic [3:0] A_CTRL  = 4'd11;
    localparam logic [3:0] A_FLAG  = 4'd12;
    localparam logic [3:0] A_VALID = 4'd13;

    localparam int C_FREEZE = 7;
    localparam int C_BIN    = 2;
    localparam int C_H24    = 1;

    localparam logic [7:0] CTRL_RST = 8'h02;
    localparam logic [6:0] STAT_RST = 7'h20;

    // Stored byte -> natural value
    function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
        logic [6:0] tens;
        tens = {3'b000, b[7:4]};
        if (bin) return b[6:0];
        return (tens << 3) + (tens << 1) + {3'b000, b[3:0]};
    endfunction

    // Natural value -> stored byte
    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [6:0] t;
        logic [6:0] o;
        if (bin) return {1'b0, v};
        t = v / 7'd10;
        o = v - (t * 7'd10);
        return {t[3:0], o[3:0]};
    endfunction

    // Stored hour byte -> 0..23
    function automatic logic [6:0] hour_to24(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [6:0] h;
        if (h24) return dec_val(b, bin);
        h = dec_val({1'b0, b[6:0]}, bin);
        if (h == 7'd12) return b[7] ? 7'd12 : 7'd0;
        return b[7] ? h + 7'd12 : h;
    endfunction

    // 0..23 -> stored hour byte
    function automatic logic [7:0] hour_from24(input logic [6:0] v, input logic bin,
                                              input logic h24);
        logic [6:0] h;
        logic [7:0] e;
        if (h24) return enc_val(v, bin);
        h = (v >= 7'd12) ? v - 7'd12 : v;
        if (h == 7'd0) h = 7'd12;
        e = enc_val(h, bin);
        return {(v >= 7'd12), e[6:0]};
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
        case (mon)
            7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
            7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            default:                 return 7'd31;
        endcase
    endfunction

    function automatic logic [3:0] state_field(input seq_state_t st);
        case (st)
            ST_MIN:  return A_MIN;
            ST_HOUR: return A_HOUR;
            ST_WDAY: return A_WDAY;
            ST_MDAY: return A_MDAY;
            ST_MON:  return A_MON;
            ST_YEAR: return A_YEAR;
            default: return A_SEC;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic hold,
    output logic lead_pulse,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST    = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] WARN_AT = CW'(TICKS_PER_SEC - 1 - LEAD_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (ref_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        lead_pulse = ref_tick && !hold && (cnt_q == WARN_AT);
        sec_pulse  = ref_tick && !hold && (cnt_q == LAST);
    end

    // R3: divider stays inside one second
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8: a frozen prescaler restarts from zero
    a_r8_prescale_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_advance.sv
`timescale 1ns/1ps
module rtc_advance
    import rtc_pkg::*;
(
    input  seq_state_t sel,
    input  logic [7:0] cur,
    input  logic [7:0] mon_b,
    input  logic [7:0] yr_b,
    input  logic       bin,
    input  logic       h24,
    output logic [7:0] nxt,
    output logic       wrap
);
    logic [6:0] v;
    logic [6:0] lim;
    logic [6:0] low;
    logic [6:0] nv;
    logic       is_hour;

    always_comb begin
        is_hour = (sel == ST_HOUR);
        v = is_hour ? hour_to24(cur, bin, h24) : dec_val(cur, bin);
        unique case (sel)
            ST_SEC, ST_MIN: begin lim = 7'd59; low = 7'd0; end
            ST_HOUR:        begin lim = 7'd23; low = 7'd0; end
            ST_WDAY:        begin lim = 7'd7;  low = 7'd1; end
            ST_MDAY:        begin
                lim = month_days(dec_val(mon_b, bin), dec_val(yr_b, bin));
                low = 7'd1;
            end
            ST_MON:         begin lim = 7'd12; low = 7'd1; end
            ST_YEAR:        begin lim = 7'd99; low = 7'd0; end
            default:        begin lim = 7'd0;  low = 7'd0; end
        endcase
        wrap = (v >= lim);
        nv   = wrap ? low : v + 7'd1;
        nxt  = is_hour ? hour_from24(nv, bin, h24) : enc_val(nv, bin);
    end

endmodule

// File: rtl/rtc_seq.sv
`timescale 1ns/1ps
module rtc_seq
    import rtc_pkg::*;
#(
    parameter int HOLD_TICKS = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       lead_pulse,
    input  logic       sec_pulse,
    input  logic       ref_tick,
    input  logic       wrap,
    input  logic       match,
    output seq_state_t state,
    output logic       step_en,
    output logic       uip,
    output logic       upd_done,
    output logic       alarm_hit
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HLAST = HW'(HOLD_TICKS - 1);

    seq_state_t    nxt_state;
    logic [HW-1:0] hcnt_q;
    logic          carry_q;
    logic          alarm_q;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:  if (!hold && lead_pulse) nxt_state = ST_WARN;
            ST_WARN:  if (hold) nxt_state = ST_IDLE;
                      else if (sec_pulse) nxt_state = ST_SEC;
            ST_SEC:   nxt_state = ST_MIN;
            ST_MIN:   nxt_state = ST_HOUR;
            ST_HOUR:  nxt_state = ST_WDAY;
            ST_WDAY:  nxt_state = ST_MDAY;
            ST_MDAY:  nxt_state = ST_MON;
            ST_MON:   nxt_state = ST_YEAR;
            ST_YEAR:  nxt_state = ST_MATCH;
            ST_MATCH: nxt_state = ST_HOLD;
            ST_HOLD:  if (ref_tick && hcnt_q == HLAST) nxt_state = ST_END;
            ST_END:   nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // State register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hcnt_q  <= '0;
            carry_q <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            state <= nxt_state;
            if (state == ST_HOLD) begin
                if (ref_tick) hcnt_q <= hcnt_q + 1'b1;
            end else begin
                hcnt_q <= '0;
            end
            if (state inside {ST_SEC, ST_MIN, ST_HOUR, ST_MDAY, ST_MON, ST_YEAR})
                carry_q <= step_en && wrap;
            if (state == ST_MATCH)
                alarm_q <= match;
        end
    end

    // Outputs
    always_comb begin
        step_en   = (state == ST_SEC) ||
                    (carry_q && (state inside {ST_MIN, ST_HOUR, ST_WDAY,
                                               ST_MDAY, ST_MON, ST_YEAR}));
        uip       = !(state inside {ST_IDLE, ST_END});
        upd_done  = (state == ST_END);
        alarm_hit = (state == ST_END) && alarm_q;
    end

    a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (!uip && $past(uip)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    a_r8_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && hold) |=> (state == ST_IDLE));

    a_r9_warn_before_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEC) |-> $past(state == ST_WARN));

    a_r11_alarm_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8,
    parameter int HOLD_TICKS    = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       uip,
    output logic       upd_done,
    output logic       alarm_hit
);
    logic [7:0] fld [NUM_FIELDS];
    logic [6:0] stat_q;
    logic [7:0] ctrl_q;

    logic       freeze, bin, h24;
    logic       lead_pulse, sec_pulse;
    seq_state_t state;
    logic       step_en, wrap, match;
    logic [7:0] cur, nxt;
    logic [3:0] step_idx;

    always_comb begin
        freeze   = ctrl_q[C_FREEZE];
        bin      = ctrl_q[C_BIN];
        h24      = ctrl_q[C_H24];
        step_idx = state_field(state);
        cur      = fld[step_idx];
        match    = (dec_val(fld[A_SEC], bin) == dec_val(fld[A_ASEC], bin)) &&
                   (dec_val(fld[A_MIN], bin) == dec_val(fld[A_AMIN], bin)) &&
                   (hour_to24(fld[A_HOUR], bin, h24) ==
                    hour_to24(fld[A_AHOUR], bin, h24));
    end

    rtc_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .LEAD_TICKS   (LEAD_TICKS)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .hold      (freeze),
        .lead_pulse(lead_pulse),
        .sec_pulse (sec_pulse)
    );

    rtc_seq #(
        .HOLD_TICKS(HOLD_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (freeze),
        .lead_pulse(lead_pulse),
        .sec_pulse (sec_pulse),
        .ref_tick  (ref_tick),
        .wrap      (wrap),
        .match     (match),
        .state     (state),
        .step_en   (step_en),
        .uip       (uip),
        .upd_done  (upd_done),
        .alarm_hit (alarm_hit)
    );

    rtc_advance u_adv (
        .sel  (state),
        .cur  (cur),
        .mon_b(fld[A_MON]),
        .yr_b (fld[A_YEAR]),
        .bin  (bin),
        .h24  (h24),
        .nxt  (nxt),
        .wrap (wrap)
    );

    // Register file: the sequencer step first, a bus write on top of it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FIELDS; i++) fld[i] <= 8'h00;
            fld[A_WDAY] <= 8'h01;
            fld[A_MDAY] <= 8'h01;
            fld[A_MON]  <= 8'h01;
            stat_q      <= STAT_RST;
            ctrl_q      <= CTRL_RST;
        end else begin
            if (step_en) fld[step_idx] <= nxt;
            if (reg_wr) begin
                if (reg_addr < A_STAT)       fld[reg_addr] <= reg_wdata;
                else if (reg_addr == A_STAT) stat_q <= reg_wdata[6:0];
                else if (reg_addr == A_CTRL) ctrl_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        if (reg_addr < A_STAT)        reg_rdata = fld[reg_addr];
        else if (reg_addr == A_STAT)  reg_rdata = {uip, stat_q};
        else if (reg_addr == A_CTRL)  reg_rdata = ctrl_q;
        else if (reg_addr == A_VALID) reg_rdata = 8'h80;
        else                          reg_rdata = 8'h00;
    end

    // R8: frozen and idle, with no write, the seconds byte holds
    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(freeze) && !$past(uip) && !$past(reg_wr)) |-> $stable(fld[A_SEC]));

    // R9: no field step happens while the busy flag is low
    a_r9_step_under_uip: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> uip);

endmodule

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;
    localparam int TPS  = 16;
    localparam int LEAD = 3;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       uip, upd_done, alarm_hit;

    int nchk = 0;
    int nerr = 0;
    int n_upd = 0;
    bit mon_busy = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] b [7];
        logic       alarm;
        string      tag;
    } exp_t;
    exp_t exp_q [$];

    rtc_calendar #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD), .HOLD_TICKS(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit));

    initial forever #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] enc(int v, bit bin);
        if (bin) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] henc(int h, bit bin, bit h24);
        logic [7:0] e;
        int hh;
        if (h24) return enc(h, bin);
        hh = h % 12;
        if (hh == 0) hh = 12;
        e = enc(hh, bin);
        return {(h >= 12) ? 1'b1 : 1'b0, e[6:0]};
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Monitor: pops one expected item per update-ended pulse
    initial begin
        exp_t e;
        logic [7:0] d;
        forever begin
            @(negedge clk);
            if (upd_done) begin
                mon_busy = 1;
                n_upd++;
                chk("R10 uip low at done", {7'd0, uip}, 8'd0);
                if (exp_q.size() == 0) begin
                    nchk++; nerr++;
                    $display("FAIL R8 unexpected update: got 1 expected 0");
                end else begin
                    e = exp_q.pop_front();
                    chk({"R11 ", e.tag}, {7'd0, alarm_hit}, {7'd0, e.alarm});
                    @(negedge clk);
                    chk("R10 single pulse", {7'd0, upd_done}, 8'd0);
                    rd(4'd0, d); chk({"R3 sec ", e.tag}, d, e.b[0]);
                    rd(4'd2, d); chk({"R3 min ", e.tag}, d, e.b[1]);
                    rd(4'd4, d); chk({"R5 hour ", e.tag}, d, e.b[2]);
                    rd(4'd6, d); chk({"R7 wday ", e.tag}, d, e.b[3]);
                    rd(4'd7, d); chk({"R6 date ", e.tag}, d, e.b[4]);
                    rd(4'd8, d); chk({"R6 month ", e.tag}, d, e.b[5]);
                    rd(4'd9, d); chk({"R6 year ", e.tag}, d, e.b[6]);
                end
                mon_busy = 0;
            end
        end
    end

    // Driver: loads a time, predicts n updates, lets the block run
    task automatic run_case(string tag, int s, int m, int h, int wd, int md, int mo,
                            int yr, logic [7:0] ctrl, int as_, int am, int ah, int n);
        bit bin = ctrl[2];
        bit h24 = ctrl[1];
        logic [7:0] d;
        logic [7:0] wv [10];
        logic [7:0] s0;
        exp_t e;
        wv[0] = enc(s, bin);       wv[1] = enc(as_, bin);
        wv[2] = enc(m, bin);       wv[3] = enc(am, bin);
        wv[4] = henc(h, bin, h24); wv[5] = henc(ah, bin, h24);
        wv[6] = enc(wd, bin);      wv[7] = enc(md, bin);
        wv[8] = enc(mo, bin);      wv[9] = enc(yr, bin);
        s0 = wv[0];
        wr(4'd11, ctrl | 8'h80);
        for (int i = 0; i < 10; i++) wr(4'(i), wv[i]);
        for (int i = 0; i < 10; i++) begin
            rd(4'(i), d);
            chk({"R2 readback ", tag}, d, wv[i]);
        end
        for (int k = 0; k < n; k++) begin
            s++;
            if (s == 60) begin
                s = 0; m++;
                if (m == 60) begin
                    m = 0; h++;
                    if (h == 24) begin
                        h = 0;
                        wd = (wd == 7) ? 1 : wd + 1;
                        md++;
                        if (md > mdays(mo, yr)) begin
                            md = 1; mo++;
                            if (mo == 13) begin
                                mo = 1; yr = (yr == 99) ? 0 : yr + 1;
                            end
                        end
                    end
                end
            end
            e.b[0] = enc(s, bin);  e.b[1] = enc(m, bin);  e.b[2] = henc(h, bin, h24);
            e.b[3] = enc(wd, bin); e.b[4] = enc(md, bin); e.b[5] = enc(mo, bin);
            e.b[6] = enc(yr, bin);
            e.alarm = (s == as_) && (m == am) && (h == ah);
            e.tag = tag;
            exp_q.push_back(e);
        end
        wr(4'd11, ctrl);
        while (!uip) @(negedge clk);
        rd(4'd0, d);
        chk({"R9 old seconds at uip rise ", tag}, d, s0);
        rd(4'd10, d);
        chk({"R9 status busy bit ", tag}, {7'd0, d[7]}, 8'd1);
        while (exp_q.size() > 0 || mon_busy) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] rst_exp [14];
        int n0;
        rst_exp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01,
                    8'h01, 8'h01, 8'h00, 8'h20, 8'h02, 8'h00, 8'h80};
        repeat (5) @(negedge clk);
        chk("R1 uip", {7'd0, uip}, 8'd0);
        chk("R1 done", {7'd0, upd_done}, 8'd0);
        chk("R1 alarm", {7'd0, alarm_hit}, 8'd0);
        rst_n = 1'b1;
        wr(4'd11, 8'h82);
        for (int i = 0; i < 14; i++) begin
            if (i == 11) continue;
            rd(4'(i), d);
            chk($sformatf("R1 reset byte %0d", i), d, rst_exp[i]);
        end

        // R12: read-only and fixed bytes
        wr(4'd13, 8'h00); rd(4'd13, d); chk("R12 valid byte", d, 8'h80);
        wr(4'd12, 8'hFF); rd(4'd12, d); chk("R12 flag byte", d, 8'h00);
        wr(4'd10, 8'hFF); rd(4'd10, d); chk("R12 busy bit read-only", d, 8'h7F);
        wr(4'd10, 8'h20);

        run_case("R4 R7 BCD new year", 58, 59, 23, 7, 31, 12, 99, 8'h02, 0, 0, 0, 2);
        run_case("R4 R6 bin leap feb28", 59, 59, 23, 3, 28, 2, 24, 8'h06, 5, 5, 5, 1);
        run_case("R6 bin leap feb29", 59, 59, 23, 4, 29, 2, 24, 8'h06, 5, 5, 5, 1);
        run_case("R6 BCD common feb28", 59, 59, 23, 2, 28, 2, 23, 8'h02, 0, 0, 0, 1);
        run_case("R6 bin apr30", 59, 59, 23, 5, 30, 4, 50, 8'h06, 1, 1, 1, 1);
        run_case("R5 BCD 11am to noon", 59, 59, 11, 1, 10, 6, 10, 8'h00, 0, 0, 12, 1);
        run_case("R5 bin 12pm to 1pm", 59, 59, 12, 1, 10, 6, 10, 8'h04, 0, 0, 3, 1);
        run_case("R5 BCD midnight", 59, 59, 23, 6, 31, 1, 10, 8'h00, 0, 0, 0, 1);
        run_case("R3 R11 bin seconds", 57, 0, 0, 1, 1, 1, 0, 8'h06, 59, 0, 0, 3);

        // R8: freeze stops updates
        wr(4'd11, 8'h82);
        rd(4'd0, d);
        n0 = n_upd;
        repeat (4 * TPS * 3) @(negedge clk);
        chk("R8 no update while frozen", 8'(n_upd - n0), 8'd0);
        begin
            logic [7:0] d2;
            rd(4'd0, d2);
            chk("R8 seconds held", d2, d);
        end
        summary();
    end
endmodule